// File: doc/BRIEF.md
# Hashed Inverted Page Table Group Lookup

This block translates a virtual page number, qualified by an address-space identifier, into a physical frame number. The page table it searches is inverted: its size follows physical memory, not the virtual address space, and it is reached through a hash of the lookup tag instead of a scan. Colliding entries are not linked through a chain. They share one fixed group of eight adjacent slots, and the whole group comes back from memory as a single wide word.

A lookup request is accepted only when the block is idle. The block then hashes the tag to a group address and issues one wide memory read. When the group returns, it registers the group and compares all eight slots against the tag at the same time. It then presents a held response: either the frame number, protection bits and slot of the match, or a miss. On a miss the block searches no further. Software finishes the search outside the group.

Each entry carries its own frame number, because the slot an entry occupies says nothing about the frame it maps. Only one lookup is in progress at any time.

Top module: `invPageGroupSearch`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `reqReady` is 1 and both `memReqValid` and `rspValid` are 0.
- R2: The group address is `tableBase + 8 * ((reqVpn[5:0] ^ reqAsid[5:0]) & 63)`. It is computed from `tableBase` and the tag as sampled in the cycle the request is accepted. `memAddr` holds that value, and `memReqValid` stays 1, until `memReqReady` is seen.
- R3: The group word holds slot i in bits [48*i+47 : 48*i]. Within a slot, bit 47 is valid, [46:39] is the address-space ID, [38:19] is the virtual page number, [18:3] is the frame number and [2:0] is the protection. A slot is a hit when valid is 1 and both tag fields equal the request. The response then reports `rspHit`=1 with that slot's frame number, protection bits and index.
- R4: When several slots hit, the response reports the lowest-index hitting slot.
- R5: When no slot hits, the response reports `rspHit`=0 with `rspPfn`, `rspProt` and `rspSlot` all 0. A slot with an equal tag but valid 0 does not hit. A slot with only one of the two tag fields equal does not hit.
- R6: `reqReady` falls in the cycle after a request is accepted and stays 0 until the response has been accepted. Requests presented while it is 0 are ignored.
- R7: Once `rspValid` is 1, it and all response fields stay unchanged until `rspReady` is 1.
- R8: `rspValid` is 0 in the cycle after the memory return and rises in the cycle after that.
- R9: Each lookup issues exactly one memory read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tableBase | input | 32 | Base address of the table, in entry units |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Block idle and able to take a request |
| reqVpn | input | 20 | Virtual page number to translate |
| reqAsid | input | 8 | Address-space identifier of the request |
| memReqValid | output | 1 | Group read request valid |
| memReqReady | input | 1 | Memory accepts the group read |
| memAddr | output | 32 | Address of the first slot of the group |
| memRspValid | input | 1 | Group word returned |
| memRspData | input | 384 | Eight packed slots |
| rspValid | output | 1 | Lookup response valid |
| rspReady | input | 1 | Response consumed |
| rspHit | output | 1 | A slot matched |
| rspPfn | output | 16 | Frame number of the matching slot |
| rspProt | output | 3 | Protection bits of the matching slot |
| rspSlot | output | 3 | Index of the matching slot |

## Verification
The hardest situations to reach are groups holding several slots with the full 28-bit tag. Next come slots whose tag matches but which are invalid, and slots that match on only one tag field. Random words almost never produce these. The stimulus therefore builds each group slot by slot, and for every slot draws among four kinds: exact tag, same page with a different identifier, same identifier with a different page, or unrelated. Directed cases add the first and last slot hitting together, a fully invalid group of exact tags, and tags that hash to the first and last group.

// File: rtl/ipgsPkg.sv
package ipgsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CMP,
    ST_RESP
  } lookupState_t;

  typedef struct packed {
    logic latchTag;
    logic captureLine;
    logic loadResult;
  } ctrlStrobes_t;

endpackage

// File: rtl/ipgsControl.sv
module ipgsControl
  import ipgsPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         memReqValid,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output logic         rspValid,
  input  logic         rspReady,
  output ctrlStrobes_t strobes
);

  lookupState_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (reqValid)    nextState = ST_ISSUE;
      ST_ISSUE: if (memReqReady) nextState = ST_WAIT;
      ST_WAIT:  if (memRspValid) nextState = ST_CMP;
      ST_CMP:                    nextState = ST_RESP;
      ST_RESP:  if (rspReady)    nextState = ST_IDLE;
      default:                   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign rspValid    = (state == ST_RESP);

  always_comb begin
    strobes             = '0;
    strobes.latchTag    = (state == ST_IDLE) && reqValid;
    strobes.captureLine = (state == ST_WAIT) && memRspValid;
    strobes.loadResult  = (state == ST_CMP);
  end

  // R6: an accepted request closes the door on the next cycle
  assert_one_inflight_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2: the group read is held until memory takes it
  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R7: a response is not withdrawn before it is consumed
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R9: no second read while the first is outstanding
  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

endmodule

// File: rtl/ipgsDatapath.sv
module ipgsDatapath
  import ipgsPkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int ASID_W     = 8,
  parameter int PFN_W      = 16,
  parameter int PROT_W     = 3,
  parameter int ADDR_W     = 32,
  parameter int GROUP_BITS = 6,
  parameter int SLOTS      = 8,
  localparam int ENTRY_W   = 1 + ASID_W + VPN_W + PFN_W + PROT_W,
  localparam int LINE_W    = SLOTS * ENTRY_W,
  localparam int SLOT_BITS = $clog2(SLOTS)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]    tableBase,
  input  logic [VPN_W-1:0]     reqVpn,
  input  logic [ASID_W-1:0]    reqAsid,
  input  logic [LINE_W-1:0]    memRspData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 rspHit,
  output logic [PFN_W-1:0]     rspPfn,
  output logic [PROT_W-1:0]    rspProt,
  output logic [SLOT_BITS-1:0] rspSlot
);

  localparam int PROT_LO   = 0;
  localparam int PFN_LO    = PROT_LO + PROT_W;
  localparam int VPN_LO    = PFN_LO + PFN_W;
  localparam int ASID_LO   = VPN_LO + VPN_W;
  localparam int VALID_BIT = ASID_LO + ASID_W;

  // tag and group address, sampled at acceptance
  logic [VPN_W-1:0]      tagVpn;
  logic [ASID_W-1:0]     tagAsid;
  logic [GROUP_BITS-1:0] groupIdx;
  logic [ADDR_W-1:0]     groupAddr;

  assign groupIdx  = reqVpn[GROUP_BITS-1:0] ^ GROUP_BITS'(reqAsid);
  assign groupAddr = tableBase + (ADDR_W'(groupIdx) << SLOT_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagVpn  <= '0;
      tagAsid <= '0;
      memAddr <= '0;
    end else if (strobes.latchTag) begin
      tagVpn  <= reqVpn;
      tagAsid <= reqAsid;
      memAddr <= groupAddr;
    end
  end

  // returned group, held for the compare cycle
  logic [LINE_W-1:0] lineReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lineReg <= '0;
    else if (strobes.captureLine) lineReg <= memRspData;
  end

  // per-slot unpack and parallel compare
  logic [SLOTS-1:0]  matchVec;
  logic [PFN_W-1:0]  slotPfn  [SLOTS];
  logic [PROT_W-1:0] slotProt [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [ENTRY_W-1:0] entry;
    assign entry       = lineReg[s*ENTRY_W +: ENTRY_W];
    assign slotPfn[s]  = entry[PFN_LO +: PFN_W];
    assign slotProt[s] = entry[PROT_LO +: PROT_W];
    assign matchVec[s] = entry[VALID_BIT]
                      && (entry[VPN_LO +: VPN_W] == tagVpn)
                      && (entry[ASID_LO +: ASID_W] == tagAsid);
  end

  // lowest index wins
  logic [SLOT_BITS-1:0] winSlot;
  logic                 anyMatch;

  always_comb begin
    winSlot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (matchVec[i]) winSlot = SLOT_BITS'(i);
    end
  end

  assign anyMatch = |matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit  <= 1'b0;
      rspPfn  <= '0;
      rspProt <= '0;
      rspSlot <= '0;
    end else if (strobes.loadResult) begin
      rspHit  <= anyMatch;
      rspPfn  <= anyMatch ? slotPfn[winSlot]  : '0;
      rspProt <= anyMatch ? slotProt[winSlot] : '0;
      rspSlot <= anyMatch ? winSlot           : '0;
    end
  end

  // R3: a reported hit names a slot that really matches the held tag
  assert_hit_names_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.loadResult) && rspHit) |-> matchVec[rspSlot]);

  // R4: no matching slot sits below the reported one
  assert_lowest_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.loadResult) && rspHit)
      |-> ((matchVec & ((SLOTS'(1) << rspSlot) - SLOTS'(1))) == '0));

  // R5: a miss carries zeroed fields and no slot matched
  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.loadResult) && !rspHit)
      |-> (rspPfn == '0 && rspProt == '0 && rspSlot == '0 && matchVec == '0));

endmodule

// File: rtl/invPageGroupSearch.sv
module invPageGroupSearch
  import ipgsPkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int ASID_W     = 8,
  parameter int PFN_W      = 16,
  parameter int PROT_W     = 3,
  parameter int ADDR_W     = 32,
  parameter int GROUP_BITS = 6,
  parameter int SLOTS      = 8,
  localparam int ENTRY_W   = 1 + ASID_W + VPN_W + PFN_W + PROT_W,
  localparam int LINE_W    = SLOTS * ENTRY_W,
  localparam int SLOT_BITS = $clog2(SLOTS)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    tableBase,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [VPN_W-1:0]     reqVpn,
  input  logic [ASID_W-1:0]    reqAsid,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memRspValid,
  input  logic [LINE_W-1:0]    memRspData,
  output logic                 rspValid,
  input  logic                 rspReady,
  output logic                 rspHit,
  output logic [PFN_W-1:0]     rspPfn,
  output logic [PROT_W-1:0]    rspProt,
  output logic [SLOT_BITS-1:0] rspSlot
);

  ctrlStrobes_t strobes;

  ipgsControl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .strobes     (strobes)
  );

  ipgsDatapath #(
    .VPN_W      (VPN_W),
    .ASID_W     (ASID_W),
    .PFN_W      (PFN_W),
    .PROT_W     (PROT_W),
    .ADDR_W     (ADDR_W),
    .GROUP_BITS (GROUP_BITS),
    .SLOTS      (SLOTS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tableBase  (tableBase),
    .reqVpn     (reqVpn),
    .reqAsid    (reqAsid),
    .memRspData (memRspData),
    .memAddr    (memAddr),
    .rspHit     (rspHit),
    .rspPfn     (rspPfn),
    .rspProt    (rspProt),
    .rspSlot    (rspSlot)
  );

  // R7: response fields are frozen while waiting for the consumer
  assert_rsp_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady)
      |=> ($stable(rspHit) && $stable(rspPfn) && $stable(rspProt) && $stable(rspSlot)));

  // R2: the group address does not move while the read is pending
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memAddr));

  // R8: the response rises two cycles after the group arrives
  assert_rsp_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(memRspValid, 2));

endmodule

// File: tb/tb_invPageGroupSearch.sv
`timescale 1ns/1ps
module tb_invPageGroupSearch;

  localparam int LINE_W = 384;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [31:0]       tableBase = '0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [19:0]       reqVpn = '0;
  logic [7:0]        reqAsid = '0;
  logic              memReqValid;
  logic              memReqReady = 1'b0;
  logic [31:0]       memAddr;
  logic              memRspValid = 1'b0;
  logic [LINE_W-1:0] memRspData = '0;
  logic              rspValid;
  logic              rspReady = 1'b0;
  logic              rspHit;
  logic [15:0]       rspPfn;
  logic [2:0]        rspProt;
  logic [2:0]        rspSlot;

  int vectors = 0;
  int miscompares = 0;
  int memIssues = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  invPageGroupSearch dut (
    .clk(clk), .rstN(rstN), .tableBase(tableBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVpn(reqVpn), .reqAsid(reqAsid),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspHit(rspHit),
    .rspPfn(rspPfn), .rspProt(rspProt), .rspSlot(rspSlot)
  );

  always @(posedge clk) if (memReqValid && memReqReady) memIssues++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mkEntry(input bit v, input logic [7:0] a,
      input logic [19:0] vp, input logic [15:0] pf, input logic [2:0] pr);
    return {v, a, vp, pf, pr};
  endfunction

  function automatic logic [31:0] expAddr(input logic [31:0] base,
      input logic [19:0] vp, input logic [7:0] a);
    return base + 32'((vp[5:0] ^ a[5:0]) & 6'h3f) * 32'd8;
  endfunction

  task automatic expResult(input logic [LINE_W-1:0] line, input logic [19:0] vp,
      input logic [7:0] a, output bit hit, output logic [15:0] pf,
      output logic [2:0] pr, output logic [2:0] sl);
    hit = 0; pf = '0; pr = '0; sl = '0;
    for (int i = 0; i < 8; i++) begin
      logic [47:0] e;
      e = line[i*48 +: 48];
      if (!hit && e[47] && e[46:39] == a && e[38:19] == vp) begin
        hit = 1; pf = e[18:3]; pr = e[2:0]; sl = 3'(i);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doLookup(input logic [19:0] vp, input logic [7:0] a,
      input logic [LINE_W-1:0] line, input int d1, input int d2, input int d3,
      input bit spam);
    bit eHit; logic [15:0] ePfn; logic [2:0] eProt; logic [2:0] eSlot;
    logic [31:0] eAddr;
    int issues0;
    expResult(line, vp, a, eHit, ePfn, eProt, eSlot);
    eAddr = expAddr(tableBase, vp, a);
    issues0 = memIssues;
    chk("R6 idle ready", 64'(reqReady), 64'd1);
    reqValid = 1; reqVpn = vp; reqAsid = a;
    tick();
    // accepted; scramble inputs that must have been sampled already
    tableBase = $urandom;
    reqValid = spam; reqVpn = ~vp; reqAsid = ~a;
    chk("R6 busy after accept", 64'(reqReady), 64'd0);
    chk("R2 read issued", 64'(memReqValid), 64'd1);
    chk("R2 group address", 64'(memAddr), 64'(eAddr));
    for (int k = 0; k < d1; k++) begin
      tick();
      chk("R2 address held", 64'(memAddr), 64'(eAddr));
      chk("R2 read held", 64'(memReqValid), 64'd1);
    end
    memReqReady = 1;
    tick();
    memReqReady = 0;
    chk("R9 read dropped after handshake", 64'(memReqValid), 64'd0);
    for (int k = 0; k < d2; k++) tick();
    memRspValid = 1; memRspData = line;
    tick();
    memRspValid = 0; memRspData = '0;
    chk("R8 no response in compare cycle", 64'(rspValid), 64'd0);
    tick();
    chk("R8 response rises", 64'(rspValid), 64'd1);
    chk(eHit ? "R3 hit flag" : "R5 miss flag", 64'(rspHit), 64'(eHit));
    chk(eHit ? "R3 frame" : "R5 frame zero", 64'(rspPfn), 64'(ePfn));
    chk(eHit ? "R3 protection" : "R5 protection zero", 64'(rspProt), 64'(eProt));
    chk(eHit ? "R4 slot" : "R5 slot zero", 64'(rspSlot), 64'(eSlot));
    for (int k = 0; k < d3; k++) begin
      tick();
      chk("R7 valid held", 64'(rspValid), 64'd1);
      chk("R7 fields held", {rspHit, rspPfn, rspProt, rspSlot}, {eHit, ePfn, eProt, eSlot});
      chk("R6 still busy", 64'(reqReady), 64'd0);
    end
    rspReady = 1; reqValid = 0;
    tick();
    rspReady = 0;
    chk("R6 ready after response", 64'(reqReady), 64'd1);
    chk("R7 response cleared", 64'(rspValid), 64'd0);
    chk("R9 one read per lookup", 64'(memIssues - issues0), 64'd1);
  endtask

  function automatic logic [LINE_W-1:0] randLine(input logic [19:0] vp, input logic [7:0] a);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < 8; i++) begin
      logic [19:0] ev; logic [7:0] ea;
      case ($urandom % 4)
        0: begin ev = vp; ea = a; end
        1: begin ev = vp; ea = a ^ 8'(1 + $urandom % 255); end
        2: begin ev = vp ^ 20'(1 + $urandom % 1000); ea = a; end
        default: begin ev = 20'($urandom); ea = 8'($urandom); end
      endcase
      l[i*48 +: 48] = mkEntry(($urandom % 4) != 0, ea, ev, 16'($urandom), 3'($urandom));
    end
    return l;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] l;
    int unsigned seedInit;
    seedInit = $urandom(32'h1f3a5);
    tick();
    // R1: reset state
    chk("R1 ready in reset", 64'(reqReady), 64'd1);
    chk("R1 no read in reset", 64'(memReqValid), 64'd0);
    chk("R1 no response in reset", 64'(rspValid), 64'd0);
    tick();
    rstN = 1;
    tick();
    chk("R1 ready after reset", 64'(reqReady), 64'd1);
    chk("R1 no read after reset", 64'(memReqValid), 64'd0);
    chk("R1 no response after reset", 64'(rspValid), 64'd0);

    // R3: single hit in slot 5
    tableBase = 32'h0001_0000;
    l = '0;
    for (int i = 0; i < 8; i++) l[i*48 +: 48] = mkEntry(1, 8'h11, 20'h00100 + 20'(i), 16'h100 + 16'(i), 3'(i));
    l[5*48 +: 48] = mkEntry(1, 8'h22, 20'h12345, 16'hbeef, 3'd6);
    doLookup(20'h12345, 8'h22, l, 2, 3, 2, 1);

    // R4: hits in slots 2 and 6
    l[2*48 +: 48] = mkEntry(1, 8'h22, 20'h12345, 16'h0a0a, 3'd1);
    l[5*48 +: 48] = mkEntry(0, 8'h22, 20'h12345, 16'hbeef, 3'd6);
    l[6*48 +: 48] = mkEntry(1, 8'h22, 20'h12345, 16'h0b0b, 3'd2);
    doLookup(20'h12345, 8'h22, l, 0, 0, 0, 0);

    // R4: first and last slot both hit
    for (int i = 0; i < 8; i++) l[i*48 +: 48] = mkEntry(1, 8'h05, 20'h00abc, 16'h7000 + 16'(i), 3'd4);
    for (int i = 1; i < 7; i++) l[i*48 +: 48] = mkEntry(1, 8'h06, 20'h00abc, 16'h1, 3'd1);
    doLookup(20'h00abc, 8'h05, l, 1, 0, 1, 1);

    // R5: equal tags, all invalid
    for (int i = 0; i < 8; i++) l[i*48 +: 48] = mkEntry(0, 8'h33, 20'h55555, 16'hffff, 3'd7);
    doLookup(20'h55555, 8'h33, l, 0, 2, 1, 0);

    // R5: page equal, identifier differs / identifier equal, page differs
    for (int i = 0; i < 8; i++)
      l[i*48 +: 48] = (i % 2 == 0) ? mkEntry(1, 8'h34, 20'h55555, 16'hffff, 3'd7)
                                   : mkEntry(1, 8'h33, 20'h55554, 16'hffff, 3'd7);
    doLookup(20'h55555, 8'h33, l, 1, 1, 0, 1);

    // R2: top group near the end of the address range; R3 hit in slot 7
    tableBase = 32'hffff_fe00;
    for (int i = 0; i < 8; i++) l[i*48 +: 48] = mkEntry(0, 8'h00, 20'h0003f, 16'h0, 3'd0);
    l[7*48 +: 48] = mkEntry(1, 8'h00, 20'h0003f, 16'hc0de, 3'd5);
    doLookup(20'h0003f, 8'h00, l, 3, 0, 0, 0);

    // R2: hash folds to group zero
    tableBase = 32'h0000_4000;
    l[7*48 +: 48] = mkEntry(1, 8'h3f, 20'hfff3f, 16'h1234, 3'd3);
    doLookup(20'hfff3f, 8'h3f, l, 0, 0, 0, 0);

    // random lookups
    for (int n = 0; n < 200; n++) begin
      logic [19:0] vp; logic [7:0] a;
      vp = 20'($urandom); a = 8'($urandom);
      tableBase = $urandom;
      doLookup(vp, a, randLine(vp, a), $urandom % 3, $urandom % 3, $urandom % 3, ($urandom % 2) == 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule